// File: doc/BRIEF.md
# Per-Thread Interrupt Presentation Context

This block keeps the interrupt presentation state for a small set of hardware threads and raises an exception line for each thread when an interrupt is more favoured than the priority the thread is currently running at. Each thread owns two 32-bit context words: a physical ring and a pool ring. Each word packs four bytes. From most to least significant they are the notification source, the current priority, the pending-priority bitmap and the backlog priority. Smaller priority numbers are more favoured. Interrupt priorities run from 0 to 7, and a pending priority p is bit (0x80 >> p) of a bitmap.

Interrupts arrive on a notify port. An interrupt can target one thread's physical ring, one thread's pool ring, or a group of threads. A group is the set of threads whose index divided by `GRP_SIZE` is equal. A group interrupt that no member can take is held as backlog in every member. It is presented later, when software lowers a member's current priority below it. Software writes context bytes and reads whole words through a register port. It takes interrupts through an acknowledge port, which returns the notification and the accepted priority and raises the current priority to match.

Top module: `thread_irq_presenter`

## Requirements
- R1: After reset every context word of both rings reads 0x00FF00FF: notification 0, current priority 0xFF, bitmap 0, backlog 0xFF. All exception lines are low.
- R2: The register address is {thread, ring, byte}, where ring 0 is physical, ring 1 is pool, and byte 0..3 selects bits [31:24], [23:16], [15:8] or [7:0]. A byte write changes only that byte. The read data is the whole addressed word.
- R3: A direct physical-ring notify of priority p sets bit (0x80 >> p) of that thread's physical bitmap. It sets the physical notification byte to 0x80 only when p is strictly less than the physical current priority. Otherwise the notification byte is left unchanged.
- R4: A pool-ring notify of priority p sets bit (0x80 >> p) of the pool bitmap. When p is below the physical current priority it sets the physical notification byte to 0x40. The pool ring's own notification and current-priority bytes are unchanged.
- R5: A group notify selects the lowest-numbered group member whose physical notification byte is 0 and whose physical current priority exceeds p. It sets that member's physical notification byte to 0x82 and its physical bitmap bit for p. No other member changes.
- R6: When no group member qualifies, no notification byte changes. Each member's backlog byte becomes the smaller of its old value and p.
- R7: The 16-bit acknowledge data is {notification, q}. If the notification byte is 0x40, q is the most favoured pool bitmap priority; otherwise q is the most favoured physical bitmap priority. An accepted acknowledge clears the notification byte and that bitmap bit and sets the physical current priority to q. When the notification byte is 0, the data is {0x00, current priority} and nothing changes.
- R8: A write of value w to the physical current-priority byte of a thread whose notification byte is 0 presents the first qualifying source among three, checked in this order: a physical bitmap priority below w gives 0x80; then a pool bitmap priority below w gives 0x40; then a backlog priority below w gives 0x82. A backlog presentation sets the physical bitmap bit for that priority and resets every group member's backlog byte to 0xFF.
- R9: A thread's exception line is high exactly when either of its notification bytes is nonzero.
- R10: In a cycle with more than one request, an acknowledge takes precedence over a register write, which takes precedence over a notify. The lower-precedence requests in that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ntf_valid | input | 1 | Notify request |
| ntf_thread | input | TW | Target thread, or any member of the target group |
| ntf_pool | input | 1 | Targets the pool ring (ignored for group notifies) |
| ntf_group | input | 1 | Group-targeted notify |
| ntf_prio | input | 3 | Interrupt priority |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | TW+3 | {thread, ring, byte} |
| reg_wdata | input | 8 | Byte write data |
| reg_rdata | output | 32 | Addressed context word |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_thread | input | TW | Thread being acknowledged |
| ack_data | output | 16 | {notification, accepted priority} |
| irq_out | output | NTHREADS | Per-thread exception line |

## Verification
The bench builds the block with four threads and `GRP_SIZE` set to 2. This gives two independent groups, so a test can check that a group notify or a backlog release in one group leaves the other group untouched. It also lets a lowest-index selection among members be observed. Directed sequences cover direct, pool, group and backlog paths, a blocked direct notify, and an acknowledge with nothing pending. A random phase mixes overlapping requests and priority writes, and a behavioural model checks every output on every clock.

// File: rtl/thread_irq_presenter.sv
module thread_irq_presenter #(
  parameter int NTHREADS = 4,
  parameter int GRP_SIZE = 4,
  localparam int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int AW = TW + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ntf_valid,
  input  logic [TW-1:0]       ntf_thread,
  input  logic                ntf_pool,
  input  logic                ntf_group,
  input  logic [2:0]          ntf_prio,
  input  logic                reg_wr,
  input  logic [AW-1:0]       reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                ack_valid,
  input  logic [TW-1:0]       ack_thread,
  output logic [15:0]         ack_data,
  output logic [NTHREADS-1:0] irq_out
);

  logic [31:0] ctx_q [NTHREADS][2];
  logic [31:0] ctx_d [NTHREADS][2];

  function automatic logic [7:0] top_prio(input logic [7:0] bm);
    logic [7:0] r;
    r = 8'hFF;
    for (int p = 7; p >= 0; p--)
      if (bm[7-p]) r = 8'(p);
    return r;
  endfunction

  wire [TW-1:0] wt    = reg_addr[AW-1:3];
  wire          wring = reg_addr[2];
  wire [1:0]    wbyte = reg_addr[1:0];

  assign reg_rdata = ctx_q[wt][wring];

  wire [7:0] a_nsr  = ctx_q[ack_thread][0][31:24];
  wire       a_ring = (a_nsr == 8'h40);
  wire [7:0] a_pri  = top_prio(ctx_q[ack_thread][a_ring][15:8]);
  assign ack_data = (a_nsr != 8'h00) ? {a_nsr, a_pri} : {8'h00, ctx_q[ack_thread][0][23:16]};

  wire [7:0] n_pri = {5'b0, ntf_prio};
  wire [7:0] n_bit = 8'h80 >> ntf_prio;

  logic [7:0] pp, qp, lb;
  logic       found;

  always_comb begin
    ctx_d = ctx_q;
    pp = top_prio(ctx_q[wt][0][15:8]);
    qp = top_prio(ctx_q[wt][1][15:8]);
    lb = ctx_q[wt][0][7:0];
    found = 1'b0;
    if (ack_valid) begin
      if (a_nsr != 8'h00) begin
        ctx_d[ack_thread][0][31:24] = 8'h00;
        ctx_d[ack_thread][0][23:16] = a_pri;
        if (a_pri < 8'd8)
          ctx_d[ack_thread][a_ring][15:8] = ctx_q[ack_thread][a_ring][15:8] & ~(8'h80 >> a_pri[2:0]);
      end
    end else if (reg_wr) begin
      case (wbyte)
        2'd0: ctx_d[wt][wring][31:24] = reg_wdata;
        2'd1: ctx_d[wt][wring][23:16] = reg_wdata;
        2'd2: ctx_d[wt][wring][15:8]  = reg_wdata;
        default: ctx_d[wt][wring][7:0] = reg_wdata;
      endcase
      if (!wring && wbyte == 2'd1 && ctx_q[wt][0][31:24] == 8'h00) begin
        if (pp < reg_wdata)
          ctx_d[wt][0][31:24] = 8'h80;
        else if (qp < reg_wdata)
          ctx_d[wt][0][31:24] = 8'h40;
        else if (lb < 8'd8 && lb < reg_wdata) begin
          ctx_d[wt][0][31:24] = 8'h82;
          ctx_d[wt][0][15:8]  = ctx_q[wt][0][15:8] | (8'h80 >> lb[2:0]);
          for (int i = 0; i < NTHREADS; i++)
            if (i / GRP_SIZE == int'(wt) / GRP_SIZE)
              ctx_d[i][0][7:0] = 8'hFF;
        end
      end
    end else if (ntf_valid) begin
      if (ntf_group) begin
        for (int i = 0; i < NTHREADS; i++)
          if (!found && i / GRP_SIZE == int'(ntf_thread) / GRP_SIZE &&
              ctx_q[i][0][31:24] == 8'h00 && n_pri < ctx_q[i][0][23:16]) begin
            found = 1'b1;
            ctx_d[i][0][31:24] = 8'h82;
            ctx_d[i][0][15:8]  = ctx_q[i][0][15:8] | n_bit;
          end
        if (!found)
          for (int i = 0; i < NTHREADS; i++)
            if (i / GRP_SIZE == int'(ntf_thread) / GRP_SIZE && n_pri < ctx_q[i][0][7:0])
              ctx_d[i][0][7:0] = n_pri;
      end else begin
        ctx_d[ntf_thread][ntf_pool][15:8] = ctx_q[ntf_thread][ntf_pool][15:8] | n_bit;
        if (n_pri < ctx_q[ntf_thread][0][23:16])
          ctx_d[ntf_thread][0][31:24] = ntf_pool ? 8'h40 : 8'h80;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHREADS; i++)
        for (int r = 0; r < 2; r++)
          ctx_q[i][r] <= 32'h00FF00FF;
    end else begin
      ctx_q <= ctx_d;
    end
  end

  wire ntf_go = ntf_valid && !ack_valid && !reg_wr;

  for (genvar g = 0; g < NTHREADS; g++) begin : g_thr
    assign irq_out[g] = (ctx_q[g][0][31:24] != 8'h00) || (ctx_q[g][1][31:24] != 8'h00);

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_thread == TW'(g)) |=> (ctx_q[g][0][31:24] == 8'h00));

    a_r7_ack_cppr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_thread == TW'(g) && ack_data[15:8] != 8'h00)
      |=> (ctx_q[g][0][23:16] == $past(ack_data[7:0])));

    a_r3_blocked_keeps_nsr: assert property (@(posedge clk) disable iff (!rst_n)
      (ntf_go && !ntf_group && !ntf_pool && ntf_thread == TW'(g) &&
       {5'b0, ntf_prio} >= ctx_q[g][0][23:16]) |=> $stable(ctx_q[g][0][31:24]));

    a_r4_pool_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ntf_go && !ntf_group && ntf_pool && ntf_thread == TW'(g))
      |=> ((ctx_q[g][1][15:8] & (8'h80 >> $past(ntf_prio))) != 8'h00));

    a_r4_pool_nsr_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ntf_go && !ntf_group && ntf_pool && ntf_thread == TW'(g))
      |=> $stable(ctx_q[g][1][31:16]));
  end

endmodule

// File: tb/thread_irq_presenter_test.sv
module thread_irq_presenter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int GS = 2;
  localparam int TW = 2;

  logic clk = 0, rst_n = 0;
  logic ntf_valid = 0, ntf_pool = 0, ntf_group = 0;
  logic [TW-1:0] ntf_thread = 0, ack_thread = 0;
  logic [2:0] ntf_prio = 0;
  logic reg_wr = 0, ack_valid = 0;
  logic [TW+2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [15:0] ack_data;
  logic [NT-1:0] irq_out;

  int total = 0, fails = 0;
  bit done = 0;

  thread_irq_presenter #(.NTHREADS(NT), .GRP_SIZE(GS)) uut (
    .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_thread(ntf_thread),
    .ntf_pool(ntf_pool), .ntf_group(ntf_group), .ntf_prio(ntf_prio),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_valid(ack_valid), .ack_thread(ack_thread), .ack_data(ack_data), .irq_out(irq_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: byte 0 notification, 1 current prio, 2 bitmap, 3 backlog
  logic [7:0] ms [NT][2][4];

  function automatic int best(logic [7:0] bm);
    for (int p = 0; p < 8; p++) if (bm & (8'h80 >> p)) return p;
    return 255;
  endfunction

  function automatic logic [31:0] mword(int t, int r);
    return {ms[t][r][0], ms[t][r][1], ms[t][r][2], ms[t][r][3]};
  endfunction

  function automatic logic [15:0] mack(int t);
    int r;
    if (ms[t][0][0] == 0) return {8'h00, ms[t][0][1]};
    r = (ms[t][0][0] == 8'h40) ? 1 : 0;
    return {ms[t][0][0], 8'(best(ms[t][r][2]))};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++)
        for (int r = 0; r < 2; r++) begin
          ms[t][r][0] = 0; ms[t][r][1] = 8'hFF; ms[t][r][2] = 0; ms[t][r][3] = 8'hFF;
        end
    end else if (ack_valid) begin
      int t, r, q;
      t = ack_thread;
      if (ms[t][0][0] != 0) begin
        r = (ms[t][0][0] == 8'h40) ? 1 : 0;
        q = best(ms[t][r][2]);
        ms[t][0][0] = 0;
        ms[t][0][1] = 8'(q);
        if (q < 8) ms[t][r][2] = ms[t][r][2] & ~(8'h80 >> q);
      end
    end else if (reg_wr) begin
      int t, r, b, w, pb, qb, lbk;
      t = reg_addr[TW+2:3]; r = reg_addr[2]; b = reg_addr[1:0]; w = reg_wdata;
      pb = best(ms[t][0][2]); qb = best(ms[t][1][2]); lbk = ms[t][0][3];
      ms[t][r][b] = reg_wdata;
      if (r == 0 && b == 1 && ms[t][0][0] == 0) begin
        if (pb < w) ms[t][0][0] = 8'h80;
        else if (qb < w) ms[t][0][0] = 8'h40;
        else if (lbk < 8 && lbk < w) begin
          ms[t][0][0] = 8'h82;
          ms[t][0][2] = ms[t][0][2] | (8'h80 >> lbk);
          for (int k = 0; k < NT; k++) if (k / GS == t / GS) ms[k][0][3] = 8'hFF;
        end
      end
    end else if (ntf_valid) begin
      int t, p, hit;
      t = ntf_thread; p = ntf_prio; hit = -1;
      if (ntf_group) begin
        for (int k = 0; k < NT; k++)
          if (hit < 0 && k / GS == t / GS && ms[k][0][0] == 0 && p < ms[k][0][1]) hit = k;
        if (hit >= 0) begin
          ms[hit][0][0] = 8'h82;
          ms[hit][0][2] = ms[hit][0][2] | (8'h80 >> p);
        end else
          for (int k = 0; k < NT; k++)
            if (k / GS == t / GS && p < ms[k][0][3]) ms[k][0][3] = 8'(p);
      end else begin
        ms[t][ntf_pool][2] = ms[t][ntf_pool][2] | (8'h80 >> p);
        if (p < ms[t][0][1]) ms[t][0][0] = ntf_pool ? 8'h40 : 8'h80;
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    logic [NT-1:0] ei;
    for (int t = 0; t < NT; t++) ei[t] = (ms[t][0][0] != 0) || (ms[t][1][0] != 0);
    chk(irq_out === ei, "R9", 32'(irq_out), 32'(ei));
    chk(reg_rdata === mword(reg_addr[TW+2:3], reg_addr[2]), "R2", reg_rdata,
        mword(reg_addr[TW+2:3], reg_addr[2]));
    chk(ack_data === mack(ack_thread), "R7", 32'(ack_data), 32'(mack(ack_thread)));
  end

  task automatic drive(bit av, int at, bit wv, int wt, int wr, int wb, int wd,
                       bit nv, int nt, bit np, bit ng, int pr);
    @(negedge clk); #1;
    ack_valid = av; ack_thread = TW'(at);
    reg_wr = wv; reg_addr = {TW'(wt), 1'(wr), 2'(wb)}; reg_wdata = 8'(wd);
    ntf_valid = nv; ntf_thread = TW'(nt); ntf_pool = np; ntf_group = ng; ntf_prio = 3'(pr);
    @(negedge clk); #1;
    ack_valid = 0; reg_wr = 0; ntf_valid = 0;
  endtask

  task automatic ntf(int t, bit pool, bit grp, int p);
    drive(0, 0, 0, 0, 0, 0, 0, 1, t, pool, grp, p);
  endtask

  task automatic wrb(int t, int r, int b, int v);
    drive(0, 0, 1, t, r, b, v, 0, 0, 0, 0, 0);
  endtask

  task automatic ack(int t, logic [15:0] exp, string req);
    @(negedge clk); #1;
    ack_valid = 1; ack_thread = TW'(t);
    #1 chk(ack_data === exp, req, 32'(ack_data), 32'(exp));
    @(negedge clk); #1 ack_valid = 0;
  endtask

  task automatic rd(int t, int r, logic [31:0] exp, string req);
    @(negedge clk); #1;
    reg_addr = {TW'(t), 1'(r), 2'd0};
    #1 chk(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic report;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < 2; r++) rd(t, r, 32'h00FF00FF, "R1");
    chk(irq_out == 0, "R1", 32'(irq_out), 0);
    // R3 direct physical interrupt, R7 acknowledge, R8 release
    ntf(1, 0, 0, 5);
    rd(1, 0, 32'h80FF04FF, "R3");
    chk(irq_out == 4'b0010, "R9", 32'(irq_out), 32'h2);
    ack(1, 16'h8005, "R7");
    rd(1, 0, 32'h000500FF, "R7");
    wrb(1, 0, 1, 8'hFF);
    rd(1, 0, 32'h00FF00FF, "R8");
    // R4 pool ring interrupt
    ntf(1, 1, 0, 5);
    rd(1, 0, 32'h40FF00FF, "R4");
    rd(1, 1, 32'h00FF04FF, "R4");
    ack(1, 16'h4005, "R7");
    rd(1, 1, 32'h00FF00FF, "R7");
    rd(1, 0, 32'h000500FF, "R7");
    wrb(1, 0, 1, 8'hFF);
    // R5 group interrupt to group {2,3}
    ntf(3, 0, 1, 6);
    rd(2, 0, 32'h82FF02FF, "R5");
    rd(3, 0, 32'h00FF00FF, "R5");
    ack(2, 16'h8206, "R7");
    wrb(2, 0, 1, 8'hFF);
    // R6 backlog in group {0,1}, R8 backlog release
    wrb(0, 0, 1, 2);
    wrb(1, 0, 1, 2);
    ntf(0, 0, 1, 3);
    rd(0, 0, 32'h00020003, "R6");
    rd(1, 0, 32'h00020003, "R6");
    rd(2, 0, 32'h00FF00FF, "R6");
    wrb(1, 0, 1, 4);
    rd(1, 0, 32'h820410FF, "R8");
    rd(0, 0, 32'h000200FF, "R8");
    ack(1, 16'h8203, "R7");
    wrb(1, 0, 1, 8'hFF);
    rd(1, 0, 32'h00FF00FF, "R8");
    wrb(0, 0, 1, 8'hFF);
    // R3 blocked direct notify, then R8 re-presentation
    wrb(3, 0, 1, 3);
    ntf(3, 0, 0, 3);
    rd(3, 0, 32'h000310FF, "R3");
    wrb(3, 0, 1, 5);
    rd(3, 0, 32'h800510FF, "R8");
    ack(3, 16'h8003, "R7");
    rd(3, 0, 32'h000300FF, "R7");
    wrb(3, 0, 1, 8'hFF);
    // R7 acknowledge with nothing pending
    ack(0, 16'h00FF, "R7");
    rd(0, 0, 32'h00FF00FF, "R7");
    // R2 byte write only, R9 pool notification byte
    wrb(2, 1, 0, 8'h11);
    rd(2, 1, 32'h11FF00FF, "R2");
    chk(irq_out == 4'b0100, "R9", 32'(irq_out), 32'h4);
    wrb(2, 1, 0, 0);
    // R10 precedence
    drive(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    rd(0, 0, 32'h00FF00FF, "R10");
    drive(0, 0, 1, 3, 0, 3, 7, 1, 3, 0, 0, 1);
    rd(3, 0, 32'h00FF0007, "R10");
    wrb(3, 0, 3, 8'hFF);
    // random mix, checked every clock by the model
    for (int n = 0; n < 3000; n++) begin
      int k, v;
      k = $urandom_range(0, 9);
      v = (k < 2) ? 8'hFF : $urandom_range(0, 8);
      drive(k == 0 || k == 9, $urandom_range(0, 3),
            k == 1 || k == 2 || k == 9, $urandom_range(0, 3), $urandom_range(0, 1),
            (k == 2) ? $urandom_range(0, 3) : 1, v,
            k >= 3, $urandom_range(0, 3), $urandom_range(0, 1), k >= 7,
            $urandom_range(0, 7));
    end
    report();
  end
endmodule